// File: doc/BRIEF.md
# Track Format Sequencer

This block runs a single track-format operation against an external floppy disk controller. After a start pulse it polls the controller's status byte to find the index hole. Before every poll it sends a force-interrupt command. It waits for the hole to appear and then to pass, and it confirms that the hole has passed before it sends the write-track command.

After the command it waits out a fixed settle interval, because the controller is not ready at once. It then waits for the first data request. While the track is being written it enables an external format stream generator, and it keeps that enable high until the controller drops busy. If the controller reports not-ready or write-protect instead of a data request, the stream phase is skipped and the error is recorded.

At the end the block captures the internal and external status bytes into one register. It issues one dummy single-byte transfer to release the controller's latched data request, and then pulses done.

Top module: `fmt_seq_ctrl`

## Requirements
- R1: While reset is held, `cmd_we_o`, `stream_en_o`, `xfer_o` and `done_o` are low and `status_o` is zero.
- R2: Every index sample is preceded by a one-cycle strobe of command 0xD0. The index state is bit 1 of `stat_i`, sampled in the cycle after that strobe, so one index sample is taken every two cycles.
- R3: The block first needs an index sample of 1, then a sample of 0, then a second consecutive sample of 0. If that confirming sample is 1, the block goes back to waiting for a 0 sample.
- R4: Each operation strobes command 0xF4 exactly once. The strobe comes two cycles after the strobe of the last 0xD0 poll.
- R5: Data request and error inputs are ignored for SETTLE_CYC cycles after the 0xF4 strobe. If `drq_i` is already high, `stream_en_o` first rises SETTLE_CYC+2 cycles after the cycle of the 0xF4 strobe.
- R6: Once a data request has ended the wait, `stream_en_o` stays high up to and including the first cycle in which `busy_i` is seen low, and then falls.
- R7: `not_ready_i` or `wr_prot_i` also ends the wait. An error takes precedence over a simultaneous `drq_i`. In that case `stream_en_o` never rises in the operation and bit 16 of the captured status is 1.
- R8: `status_o` is loaded once per operation, at the edge that starts the dummy transfer. Bits 7:0 hold `stat_i`, bits 15:8 hold `ext_stat_i` and bit 16 holds the error flag. It holds that value until the next operation.
- R9: `xfer_o` pulses for exactly one cycle, two cycles after the last cycle of `stream_en_o`. `done_o` pulses for exactly one cycle in the cycle right after `xfer_o`.
- R10: A start pulse that arrives while an operation is in progress is ignored. It starts no new poll and issues no command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start one format operation (pulse) |
| cmd_o | output | 8 | Command byte to the controller |
| cmd_we_o | output | 1 | Command write strobe |
| stat_i | input | STAT_W | Controller internal status byte, bit 1 is index |
| ext_stat_i | input | STAT_W | External status byte |
| busy_i | input | 1 | Controller busy |
| drq_i | input | 1 | Controller data request |
| not_ready_i | input | 1 | Drive not ready |
| wr_prot_i | input | 1 | Media write-protected |
| stream_en_o | output | 1 | Enable for the format stream generator |
| xfer_o | output | 1 | Dummy single-byte transfer request |
| done_o | output | 1 | Operation complete (pulse) |
| status_o | output | 2*STAT_W+1 | Captured {error, external, internal} status |

## Verification
The assertions assume that the controller's status inputs change only between clock edges. They also assume that `busy_i` eventually falls once the stream has started; otherwise the run phase never ends. The bench drives the index bit afresh after each force-interrupt strobe, from a per-poll pattern. It raises the data request or the error flags only at the write-track strobe, and it drops busy after a chosen number of stream cycles. This keeps every input stable across the edge at which it is sampled.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_IDX_HI,
        ST_WAIT_IDX_LO,
        ST_CONFIRM_LO,
        ST_ISSUE,
        ST_SETTLE,
        ST_WAIT_FIRST,
        ST_RUN,
        ST_CAPTURE,
        ST_FLUSH,
        ST_DONE
    } fsc_state_e;

    localparam logic [7:0] FSC_CMD_FORCE_INT   = 8'hD0;
    localparam logic [7:0] FSC_CMD_WRITE_TRACK = 8'hF4;
    localparam int         FSC_IDX_BIT         = 1;

    typedef struct packed {
        fsc_state_e state;
        logic       poll_ph;   // 0: send force-interrupt, 1: sample index
        logic       err;
    } fsc_ctl_t;

endpackage

// File: rtl/fsc_settle_timer.sv
module fsc_settle_timer #(
    parameter int CYC = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic tick_i,
    output logic expired_o
);
    generate
        if (CYC == 0) begin : g_bypass
            assign expired_o = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(CYC + 1);
            localparam logic [CW-1:0] LOAD_VAL = CW'(CYC - 1);

            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (load_i)
                    cnt_d = LOAD_VAL;
                else if (tick_i && cnt_q != '0)
                    cnt_d = cnt_q - 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign expired_o = (cnt_q == '0);
        end
    endgenerate
endmodule

// File: rtl/fsc_status_cap.sv
module fsc_status_cap #(
    parameter int STAT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_i,
    input  logic                err_i,
    input  logic [STAT_W-1:0]   int_i,
    input  logic [STAT_W-1:0]   ext_i,
    output logic [2*STAT_W:0]   status_o
);
    logic [2*STAT_W:0] stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (cap_i) stat_d = {err_i, ext_i, int_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign status_o = stat_q;
endmodule

// File: rtl/fmt_seq_ctrl.sv
module fmt_seq_ctrl
    import fsc_pkg::*;
#(
    parameter int STAT_W     = 8,
    parameter int SETTLE_CYC = 18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    output logic [7:0]          cmd_o,
    output logic                cmd_we_o,
    input  logic [STAT_W-1:0]   stat_i,
    input  logic [STAT_W-1:0]   ext_stat_i,
    input  logic                busy_i,
    input  logic                drq_i,
    input  logic                not_ready_i,
    input  logic                wr_prot_i,
    output logic                stream_en_o,
    output logic                xfer_o,
    output logic                done_o,
    output logic [2*STAT_W:0]   status_o
);
    fsc_ctl_t ctl_d, ctl_q;
    logic     tmr_load, tmr_tick, tmr_expired;
    logic     cap_en;
    logic     idx;
    logic     polling;

    assign idx = stat_i[FSC_IDX_BIT];

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_tick = 1'b0;
        cap_en   = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.state   = ST_WAIT_IDX_HI;
                    ctl_d.poll_ph = 1'b0;
                    ctl_d.err     = 1'b0;
                end
            end
            ST_WAIT_IDX_HI: begin
                ctl_d.poll_ph = ~ctl_q.poll_ph;
                if (ctl_q.poll_ph && idx) ctl_d.state = ST_WAIT_IDX_LO;
            end
            ST_WAIT_IDX_LO: begin
                ctl_d.poll_ph = ~ctl_q.poll_ph;
                if (ctl_q.poll_ph && !idx) ctl_d.state = ST_CONFIRM_LO;
            end
            ST_CONFIRM_LO: begin
                ctl_d.poll_ph = ~ctl_q.poll_ph;
                if (ctl_q.poll_ph)
                    ctl_d.state = idx ? ST_WAIT_IDX_LO : ST_ISSUE;
            end
            ST_ISSUE: begin
                tmr_load    = 1'b1;
                ctl_d.state = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (tmr_expired) ctl_d.state = ST_WAIT_FIRST;
                else             tmr_tick    = 1'b1;
            end
            ST_WAIT_FIRST: begin
                // error wins over a simultaneous data request
                if (not_ready_i || wr_prot_i) begin
                    ctl_d.err   = 1'b1;
                    ctl_d.state = ST_CAPTURE;
                end else if (drq_i) begin
                    ctl_d.state = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!busy_i) ctl_d.state = ST_CAPTURE;
            end
            ST_CAPTURE: begin
                cap_en      = 1'b1;
                ctl_d.state = ST_FLUSH;
            end
            ST_FLUSH: ctl_d.state = ST_DONE;
            ST_DONE:  ctl_d.state = ST_IDLE;
            default:  ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state   <= ST_IDLE;
            ctl_q.poll_ph <= 1'b0;
            ctl_q.err     <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign polling = (ctl_q.state == ST_WAIT_IDX_HI) ||
                     (ctl_q.state == ST_WAIT_IDX_LO) ||
                     (ctl_q.state == ST_CONFIRM_LO);

    always_comb begin
        cmd_we_o = 1'b0;
        cmd_o    = '0;
        if (ctl_q.state == ST_ISSUE) begin
            cmd_we_o = 1'b1;
            cmd_o    = FSC_CMD_WRITE_TRACK;
        end else if (polling && !ctl_q.poll_ph) begin
            cmd_we_o = 1'b1;
            cmd_o    = FSC_CMD_FORCE_INT;
        end
    end

    assign stream_en_o = (ctl_q.state == ST_RUN);
    assign xfer_o      = (ctl_q.state == ST_FLUSH);
    assign done_o      = (ctl_q.state == ST_DONE);

    fsc_settle_timer #(.CYC(SETTLE_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .tick_i    (tmr_tick),
        .expired_o (tmr_expired)
    );

    fsc_status_cap #(.STAT_W(STAT_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_i    (cap_en),
        .err_i    (ctl_q.err),
        .int_i    (stat_i),
        .ext_i    (ext_stat_i),
        .status_o (status_o)
    );
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
    parameter int STAT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        cmd_o,
    input logic              cmd_we_o,
    input logic              idx_i,
    input logic              busy_i,
    input logic              stream_en_o,
    input logic              xfer_o,
    input logic              done_o,
    input logic [2*STAT_W:0] status_o
);
    localparam logic [7:0] C_FI = 8'hD0;
    localparam logic [7:0] C_WT = 8'hF4;

    AST_CMD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we_o |-> (cmd_o == C_FI || cmd_o == C_WT)); // R2

    AST_WT_IDX_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we_o && cmd_o == C_WT) |-> (!$past(idx_i) && !$past(cmd_we_o))); // R3

    AST_WT_AFTER_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we_o && cmd_o == C_WT) |-> ($past(cmd_we_o, 2) && $past(cmd_o, 2) == C_FI)); // R4

    AST_NO_CMD_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        stream_en_o |-> !cmd_we_o); // R10

    AST_STREAM_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_en_o && !busy_i) |=> !stream_en_o); // R6

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_o) |-> xfer_o); // R8

    AST_XFER_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stream_en_o) |=> xfer_o); // R9

    AST_XFER_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_o |=> (done_o && !xfer_o)); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
endmodule

bind fmt_seq_ctrl fsc_checker #(.STAT_W(STAT_W)) u_fsc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_o       (cmd_o),
    .cmd_we_o    (cmd_we_o),
    .idx_i       (stat_i[1]),
    .busy_i      (busy_i),
    .stream_en_o (stream_en_o),
    .xfer_o      (xfer_o),
    .done_o      (done_o),
    .status_o    (status_o)
);

// File: tb/fmt_seq_ctrl_tb.sv
module fmt_seq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int STAT_W     = 8;
    localparam int SETTLE     = 18;
    localparam int NVEC       = 5;

    // fields: pat[41:26] per-poll index, mode[25:24] (0 drq,1 nr,2 wp,3 drq+wp),
    //         run[23:16] stream cycles, int[15:8], ext[7:0]
    localparam logic [41:0] VEC [NVEC] = '{
        {16'h000C, 2'd0, 8'd5, 8'h20, 8'h41},
        {16'h0005, 2'd1, 8'd0, 8'h80, 8'h03},
        {16'h00F0, 2'd2, 8'd0, 8'h40, 8'h10},
        {16'h0001, 2'd3, 8'd0, 8'h44, 8'hA5},
        {16'h0002, 2'd0, 8'd1, 8'h00, 8'hFF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [7:0] cmd_o;
    logic cmd_we_o;
    logic [STAT_W-1:0] stat_i = '0;
    logic [STAT_W-1:0] ext_stat_i = '0;
    logic busy_i = 1'b1;
    logic drq_i = 1'b0;
    logic not_ready_i = 1'b0;
    logic wr_prot_i = 1'b0;
    logic stream_en_o, xfer_o, done_o;
    logic [2*STAT_W:0] status_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fmt_seq_ctrl #(.STAT_W(STAT_W), .SETTLE_CYC(SETTLE)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .cmd_o(cmd_o), .cmd_we_o(cmd_we_o),
        .stat_i(stat_i), .ext_stat_i(ext_stat_i),
        .busy_i(busy_i), .drq_i(drq_i), .not_ready_i(not_ready_i), .wr_prot_i(wr_prot_i),
        .stream_en_o(stream_en_o), .xfer_o(xfer_o), .done_o(done_o),
        .status_o(status_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_polls(input logic [15:0] pat);
        int st = 0;
        for (int n = 0; n < 64; n++) begin
            logic b;
            b = (n < 16) ? pat[n] : 1'b0;
            case (st)
                0: if (b) st = 1;
                1: if (!b) st = 2;
                default: if (!b) return n + 1; else st = 1;
            endcase
        end
        return -1;
    endfunction

    task automatic run_op(input logic [41:0] v, input bit poke);
        logic [15:0] pat;
        logic [1:0]  mode;
        int run;
        logic [7:0] intv, extv;
        int polls = 0, f4_cnt = 0, f4_cyc = 0, last_d0 = 0;
        int en_cnt = 0, first_en = -1, last_en = 0;
        int xfer_cnt = 0, xfer_cyc = 0, done_cnt = 0, done_cyc = 0;
        logic cur_idx = 1'b0, idx_at_f4 = 1'b1;
        logic [2*STAT_W:0] st_snap = '0;
        logic exp_err;
        pat = v[41:26]; mode = v[25:24]; run = int'(v[23:16]);
        intv = v[15:8]; extv = v[7:0];
        exp_err = (mode != 2'd0);

        @(negedge clk);
        stat_i = '0; ext_stat_i = extv; busy_i = 1'b1;
        drq_i = 1'b0; not_ready_i = 1'b0; wr_prot_i = 1'b0;
        start_i = 1'b1;
        for (int c = 1; c < 3000 && done_cnt == 0; c++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (cmd_we_o && cmd_o == 8'hD0) begin
                last_d0 = c;
                cur_idx = (polls < 16) ? pat[polls] : 1'b0;
                polls++;
                stat_i = {6'b0, cur_idx, 1'b0};
            end
            if (cmd_we_o && cmd_o == 8'hF4) begin
                f4_cnt++; f4_cyc = c; idx_at_f4 = cur_idx;
                stat_i = intv;
                drq_i = (mode == 2'd0 || mode == 2'd3);
                not_ready_i = (mode == 2'd1);
                wr_prot_i = (mode == 2'd2 || mode == 2'd3);
            end
            if (stream_en_o) begin
                en_cnt++;
                if (first_en < 0) first_en = c;
                last_en = c;
                if (en_cnt == run) busy_i = 1'b0;
                if (poke && en_cnt == 1) start_i = 1'b1;
            end
            if (xfer_o) begin xfer_cnt++; xfer_cyc = c; end
            if (done_o) begin done_cnt++; done_cyc = c; st_snap = status_o; end
        end
        drq_i = 1'b0; not_ready_i = 1'b0; wr_prot_i = 1'b0; busy_i = 1'b1;

        chk(polls == exp_polls(pat), "R2/R3 poll count", polls, exp_polls(pat));
        chk(idx_at_f4 == 1'b0, "R3 index low at write-track", idx_at_f4, 0);
        chk(f4_cnt == 1, "R4 write-track count", f4_cnt, 1);
        chk(f4_cyc - last_d0 == 2, "R4 write-track spacing", f4_cyc - last_d0, 2);
        if (!exp_err) begin
            chk(first_en - f4_cyc == SETTLE + 2, "R5 settle delay", first_en - f4_cyc, SETTLE + 2);
            chk(en_cnt == run, "R6 stream cycles", en_cnt, run);
            chk(xfer_cyc - last_en == 2, "R9 transfer after stream", xfer_cyc - last_en, 2);
        end else begin
            chk(en_cnt == 0, "R7 stream skipped on error", en_cnt, 0);
        end
        chk(st_snap == {exp_err, extv, intv}, "R7/R8 captured status", st_snap, {exp_err, extv, intv});
        chk(xfer_cnt == 1, "R9 one transfer", xfer_cnt, 1);
        chk(done_cnt == 1 && done_cyc - xfer_cyc == 1, "R9 done after transfer", done_cyc - xfer_cyc, 1);

        if (poke) begin
            int extra = 0;
            logic [2*STAT_W:0] held;
            held = status_o;
            for (int c = 0; c < 20; c++) begin
                @(negedge clk);
                if (cmd_we_o || stream_en_o) extra++;
            end
            chk(extra == 0, "R10 start ignored while active", extra, 0);
            chk(status_o == held, "R8/R10 status held", status_o, held);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        start_i = 1'b1;   // must not matter under reset
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!cmd_we_o && !stream_en_o && !xfer_o && !done_o, "R1 outputs idle in reset",
            {cmd_we_o, stream_en_o, xfer_o, done_o}, 0);
        chk(status_o == '0, "R1 status cleared", status_o, 0);
        start_i = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!cmd_we_o, "R1 idle without start", cmd_we_o, 0);

        for (int i = 0; i < NVEC; i++) run_op(VEC[i], 1'b0);

        // R10: start pulse during stream phase is ignored
        run_op({16'h0006, 2'd0, 8'd4, 8'h5A, 8'hC3}, 1'b1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule